// File: doc/BRIEF.md
# Uniform Grid Voxel Walker

This block moves one ray at a time through a uniform three-dimensional grid of cells. It uses an incremental digital differential analyser in fixed point. The ray arrives already set up: its starting cell, one direction bit per axis, the parametric distance to the next cell boundary on each axis, the per-cell increment of that distance, and the size of the grid. The walker latches all of this when it accepts the ray. It then visits cells one after another, and for each cell it reads a word from an external grid memory. A zero word marks an empty cell. Any other value points to the list of primitives held in that cell.

When the walker reaches an occupied cell, it stops and offers the cell coordinates, the cell's linear address and the list pointer on a valid/ready output. It then waits, with its stepping state kept, until the downstream stage reports that this cell produced no usable hit and raises `resume`. The walker then carries on from the next cell. If a step would leave the grid, the walker raises a one-cycle miss flag and returns to idle to take the next ray.

Top module: `voxel_walker`

## Requirements
- R1: After reset, `rayReady` is 1, and `hitValid`, `rayMiss` and `gridRd` are all 0.
- R2: A ray is accepted only on a clock edge where `rayValid` and `rayReady` are both 1. `rayReady` stays 0 from that edge until the walk has ended with a miss. Values on the ray inputs while the walker is busy have no effect on the walk.
- R3: Each grid read raises `gridRd` for one cycle with `gridAddr` = x + dimX*(y + dimY*z). The memory answers on `gridPtr` in the next cycle.
- R4: Each step picks the axis with the smallest boundary distance. Ties go to x first, then y, then z. The step adds that axis's increment to its boundary distance and moves its cell index by one. Bit 0, 1 and 2 of `stepNeg` belong to x, y and z, and a 1 means the index is decremented.
- R5: A grid word of 0 makes the walker step on. Any other word raises `hitValid`, with `hitX`/`hitY`/`hitZ`, `hitAddr` and `hitPtr` giving the cell, its linear address and the word.
- R6: While `hitValid` is 1 and `hitReady` is 0, the hit outputs hold their values. The offer ends on the edge where `hitReady` is 1.
- R7: A step that would take an index below 0 or above dim-1 ends the walk. `rayMiss` is then 1 for exactly one cycle, and `rayReady` is 1 in the cycle after it.
- R8: `resume` takes effect only after a hit has been handed off. It then steps once from the saved state and continues the walk. At any other time, `resume` is ignored.
- R9: Every cell visited costs two cycles. A result appears 2*n clock edges after acceptance or after `resume`, where n is the number of cells read. A resume whose first step leaves the grid shows `rayMiss` right after the resume edge.
- R10: The first cell read after acceptance is the origin cell itself, with no step before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rayValid | input | 1 | Ray descriptor present |
| rayReady | output | 1 | Walker idle and able to take a ray |
| originX | input | CW | Starting cell, x |
| originY | input | CW | Starting cell, y |
| originZ | input | CW | Starting cell, z |
| stepNeg | input | 3 | Per-axis direction, 1 = decrement (bit 0 x, bit 1 y, bit 2 z) |
| tMaxX | input | TW | Distance to first x boundary |
| tMaxY | input | TW | Distance to first y boundary |
| tMaxZ | input | TW | Distance to first z boundary |
| tDeltaX | input | TW | Distance per cell along x |
| tDeltaY | input | TW | Distance per cell along y |
| tDeltaZ | input | TW | Distance per cell along z |
| dimX | input | CW+1 | Grid cells along x |
| dimY | input | CW+1 | Grid cells along y |
| dimZ | input | CW+1 | Grid cells along z |
| gridRd | output | 1 | Grid memory read strobe |
| gridAddr | output | 3*CW | Linear cell address of the read |
| gridPtr | input | PW | Grid word, one cycle after the read |
| hitValid | output | 1 | Occupied cell offered |
| hitReady | input | 1 | Downstream takes the offered cell |
| hitX | output | CW | Offered cell, x |
| hitY | output | CW | Offered cell, y |
| hitZ | output | CW | Offered cell, z |
| hitAddr | output | 3*CW | Offered cell linear address |
| hitPtr | output | PW | List pointer of the offered cell |
| resume | input | 1 | No hit in the handed-off cell, continue the walk |
| rayMiss | output | 1 | One-cycle pulse, ray left the grid |

## Verification
The bench counts clock edges from the acceptance edge, or from the `resume` edge, to the first falling edge where `hitValid` or `rayMiss` shows. It expects exactly twice the number of cells that its own walk model reads. The one exception is a resume whose first step leaves the grid, which is due right after the resume edge. All outputs are sampled on falling edges, half a cycle away from the edges that move the state. The bench holds `rayValid` and `resume` high with junk values during every wait, so a leak of either input shows up as a wrong count or a wrong cell. Hit fields are compared once when they first appear and again on every cycle of a random stall.

// File: rtl/vw_pkg.sv
package vw_pkg;
  typedef struct packed {
    logic load;
    logic capPtr;
    logic doStep;
  } vwCtrl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_QUERY, S_WAIT, S_HIT, S_PARK, S_MISS
  } vwState_t;
endpackage

// File: rtl/vw_datapath.sv
module vw_datapath
  import vw_pkg::*;
#(
  parameter int CW = 4,
  parameter int TW = 16,
  parameter int PW = 12,
  localparam int AW = 3 * CW,
  localparam int DW = CW + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  vwCtrl_t               ctrl,
  input  logic [2:0][CW-1:0]    cellIn,
  input  logic [2:0]            negIn,
  input  logic [2:0][TW-1:0]    tMaxIn,
  input  logic [2:0][TW-1:0]    tDeltaIn,
  input  logic [2:0][DW-1:0]    dimIn,
  input  logic [PW-1:0]         gridPtr,
  output logic [2:0][CW-1:0]    cellQ,
  output logic [AW-1:0]         linAddr,
  output logic [PW-1:0]         ptrQ,
  output logic                  ptrNull,
  output logic                  exitFlag
);
  localparam int LW = 4 * CW + 5;

  logic [2:0][TW-1:0] tMaxQ;
  logic [2:0][TW-1:0] tDeltaQ;
  logic [2:0][DW-1:0] dimQ;
  logic [2:0]         negQ;
  logic [2:0]         axisOh;
  logic [2:0]         atEdge;
  logic [LW-1:0]      linWide;

  // smallest boundary distance wins, ties resolved x > y > z
  always_comb begin
    axisOh = 3'b000;
    if (tMaxQ[0] <= tMaxQ[1] && tMaxQ[0] <= tMaxQ[2]) axisOh = 3'b001;
    else if (tMaxQ[1] <= tMaxQ[2])                    axisOh = 3'b010;
    else                                              axisOh = 3'b100;
  end

  assign exitFlag = |(axisOh & atEdge);
  assign ptrNull  = (gridPtr == '0);

  generate
    for (genvar a = 0; a < 3; a++) begin : g_axis
      assign atEdge[a] = negQ[a] ? (cellQ[a] == '0)
                                 : ({1'b0, cellQ[a]} == dimQ[a] - DW'(1));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cellQ[a]   <= '0;
          tMaxQ[a]   <= '0;
          tDeltaQ[a] <= '0;
          dimQ[a]    <= '0;
          negQ[a]    <= 1'b0;
        end else if (ctrl.load) begin
          cellQ[a]   <= cellIn[a];
          tMaxQ[a]   <= tMaxIn[a];
          tDeltaQ[a] <= tDeltaIn[a];
          dimQ[a]    <= dimIn[a];
          negQ[a]    <= negIn[a];
        end else if (ctrl.doStep && axisOh[a] && !exitFlag) begin
          cellQ[a] <= negQ[a] ? cellQ[a] - CW'(1) : cellQ[a] + CW'(1);
          tMaxQ[a] <= tMaxQ[a] + tDeltaQ[a];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptrQ <= '0;
    else if (ctrl.capPtr) ptrQ <= gridPtr;
  end

  assign linWide = LW'(cellQ[0]) + LW'(dimQ[0]) *
                   (LW'(cellQ[1]) + LW'(dimQ[1]) * LW'(cellQ[2]));
  assign linAddr = linWide[AW-1:0];
endmodule

// File: rtl/vw_control.sv
module vw_control
  import vw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rayValid,
  input  logic    hitReady,
  input  logic    resume,
  input  logic    ptrNull,
  input  logic    exitFlag,
  output vwCtrl_t ctrl,
  output logic    rayReady,
  output logic    gridRd,
  output logic    hitValid,
  output logic    rayMiss
);
  vwState_t state, stateNxt;

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: if (rayValid) begin
        ctrl.load = 1'b1;
        stateNxt  = S_QUERY;
      end
      S_QUERY: stateNxt = S_WAIT;
      S_WAIT: begin
        ctrl.capPtr = 1'b1;
        if (!ptrNull) stateNxt = S_HIT;
        else begin
          ctrl.doStep = 1'b1;
          stateNxt    = exitFlag ? S_MISS : S_QUERY;
        end
      end
      S_HIT: if (hitReady) stateNxt = S_PARK;
      S_PARK: if (resume) begin
        ctrl.doStep = 1'b1;
        stateNxt    = exitFlag ? S_MISS : S_QUERY;
      end
      S_MISS: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign rayReady = (state == S_IDLE);
  assign gridRd   = (state == S_QUERY);
  assign hitValid = (state == S_HIT);
  assign rayMiss  = (state == S_MISS);
endmodule

// File: rtl/voxel_walker.sv
module voxel_walker
  import vw_pkg::*;
#(
  parameter int CW = 4,
  parameter int TW = 16,
  parameter int PW = 12,
  localparam int AW = 3 * CW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rayValid,
  output logic          rayReady,
  input  logic [CW-1:0] originX,
  input  logic [CW-1:0] originY,
  input  logic [CW-1:0] originZ,
  input  logic [2:0]    stepNeg,
  input  logic [TW-1:0] tMaxX,
  input  logic [TW-1:0] tMaxY,
  input  logic [TW-1:0] tMaxZ,
  input  logic [TW-1:0] tDeltaX,
  input  logic [TW-1:0] tDeltaY,
  input  logic [TW-1:0] tDeltaZ,
  input  logic [CW:0]   dimX,
  input  logic [CW:0]   dimY,
  input  logic [CW:0]   dimZ,
  output logic          gridRd,
  output logic [AW-1:0] gridAddr,
  input  logic [PW-1:0] gridPtr,
  output logic          hitValid,
  input  logic          hitReady,
  output logic [CW-1:0] hitX,
  output logic [CW-1:0] hitY,
  output logic [CW-1:0] hitZ,
  output logic [AW-1:0] hitAddr,
  output logic [PW-1:0] hitPtr,
  input  logic          resume,
  output logic          rayMiss
);
  vwCtrl_t            ctrl;
  logic [2:0][CW-1:0] cellQ;
  logic [AW-1:0]      linAddr;
  logic               ptrNull;
  logic               exitFlag;

  vw_datapath #(.CW(CW), .TW(TW), .PW(PW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .cellIn   ({originZ, originY, originX}),
    .negIn    (stepNeg),
    .tMaxIn   ({tMaxZ, tMaxY, tMaxX}),
    .tDeltaIn ({tDeltaZ, tDeltaY, tDeltaX}),
    .dimIn    ({dimZ, dimY, dimX}),
    .gridPtr  (gridPtr),
    .cellQ    (cellQ),
    .linAddr  (linAddr),
    .ptrQ     (hitPtr),
    .ptrNull  (ptrNull),
    .exitFlag (exitFlag)
  );

  vw_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .rayValid (rayValid),
    .hitReady (hitReady),
    .resume   (resume),
    .ptrNull  (ptrNull),
    .exitFlag (exitFlag),
    .ctrl     (ctrl),
    .rayReady (rayReady),
    .gridRd   (gridRd),
    .hitValid (hitValid),
    .rayMiss  (rayMiss)
  );

  assign gridAddr = linAddr;
  assign hitAddr  = linAddr;
  assign hitX     = cellQ[0];
  assign hitY     = cellQ[1];
  assign hitZ     = cellQ[2];
endmodule

// File: rtl/voxel_walker_chk.sv
module voxel_walker_chk #(
  parameter int CW = 4,
  parameter int PW = 12,
  localparam int AW = 3 * CW
) (
  input logic          clk,
  input logic          rstN,
  input logic          rayValid,
  input logic          rayReady,
  input logic          gridRd,
  input logic          hitValid,
  input logic          hitReady,
  input logic [CW-1:0] hitX,
  input logic [CW-1:0] hitY,
  input logic [CW-1:0] hitZ,
  input logic [AW-1:0] hitAddr,
  input logic [PW-1:0] hitPtr,
  input logic          rayMiss
);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    rayValid && rayReady |=> !rayReady);

  a_r3_single_cycle_read: assert property (@(posedge clk) disable iff (!rstN)
    gridRd |=> !gridRd);

  a_r9_read_then_wait: assert property (@(posedge clk) disable iff (!rstN)
    gridRd |=> !hitValid && !rayMiss && !rayReady);

  a_r5_hit_nonnull: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> hitPtr != '0);

  a_r6_hit_hold: assert property (@(posedge clk) disable iff (!rstN)
    hitValid && !hitReady |=> hitValid && $stable(hitPtr) && $stable(hitAddr)
      && $stable(hitX) && $stable(hitY) && $stable(hitZ));

  a_r6_hit_release: assert property (@(posedge clk) disable iff (!rstN)
    hitValid && hitReady |=> !hitValid);

  a_r7_miss_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rayMiss |=> !rayMiss && rayReady);

  a_r7_outcome_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hitValid, rayMiss, rayReady, gridRd}));
endmodule

bind voxel_walker voxel_walker_chk #(.CW(CW), .PW(PW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rayValid (rayValid),
  .rayReady (rayReady),
  .gridRd   (gridRd),
  .hitValid (hitValid),
  .hitReady (hitReady),
  .hitX     (hitX),
  .hitY     (hitY),
  .hitZ     (hitZ),
  .hitAddr  (hitAddr),
  .hitPtr   (hitPtr),
  .rayMiss  (rayMiss)
);

// File: tb/voxel_walker_tb.sv
`timescale 1ns/1ps
module voxel_walker_tb;
  localparam int CW = 4;
  localparam int TW = 16;
  localparam int PW = 12;
  localparam int AW = 3 * CW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rayValid = 1'b0, rayReady;
  logic [CW-1:0] originX = '0, originY = '0, originZ = '0;
  logic [2:0] stepNeg = '0;
  logic [TW-1:0] tMaxX = '0, tMaxY = '0, tMaxZ = '0;
  logic [TW-1:0] tDeltaX = '0, tDeltaY = '0, tDeltaZ = '0;
  logic [CW:0] dimX = '0, dimY = '0, dimZ = '0;
  logic gridRd;
  logic [AW-1:0] gridAddr;
  logic [PW-1:0] gridPtr = '0;
  logic hitValid, hitReady = 1'b0;
  logic [CW-1:0] hitX, hitY, hitZ;
  logic [AW-1:0] hitAddr;
  logic [PW-1:0] hitPtr;
  logic resume = 1'b0, rayMiss;

  always #4 clk = ~clk;

  voxel_walker #(.CW(CW), .TW(TW), .PW(PW)) u_dut (.*);

  int nChecks = 0, nFails = 0;
  int memMode = 0;   // 0 hashed occupancy, 1 all empty, 2 single target
  int salt = 0, target = 0;

  // model walk state
  int mc[3], mt[3], md[3], mdim[3];
  bit mneg[3];

  function automatic int ptrAt(int addr);
    if (memMode == 1) return 0;
    if (memMode == 2) return (addr == target) ? addr + 1 : 0;
    return (((addr * 37 + salt) % 5) == 0) ? addr + 1 : 0;
  endfunction

  function automatic int mAddr();
    return mc[0] + mdim[0] * (mc[1] + mdim[1] * mc[2]);
  endfunction

  always_ff @(posedge clk) if (gridRd) gridPtr <= PW'(ptrAt(int'(gridAddr)));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelStep(output bit ok);
    int a;
    if (mt[0] <= mt[1] && mt[0] <= mt[2]) a = 0;
    else if (mt[1] <= mt[2])              a = 1;
    else                                  a = 2;
    if (mneg[a] ? (mc[a] == 0) : (mc[a] == mdim[a] - 1)) begin
      ok = 1'b0;
      return;
    end
    mc[a] = mneg[a] ? mc[a] - 1 : mc[a] + 1;
    mt[a] = mt[a] + md[a];
    ok = 1'b1;
  endtask

  task automatic modelWalk(input bit stepFirst, output bit isHit, output int visits);
    bit ok;
    visits = 0;
    isHit = 1'b0;
    if (stepFirst) begin
      modelStep(ok);
      if (!ok) return;
    end
    forever begin
      visits++;
      if (ptrAt(mAddr()) != 0) begin
        isHit = 1'b1;
        return;
      end
      modelStep(ok);
      if (!ok) return;
    end
  endtask

  task automatic junkInputs();
    originX = CW'($urandom); originY = CW'($urandom); originZ = CW'($urandom);
    stepNeg = 3'($urandom);
    tMaxX = TW'($urandom); tMaxY = TW'($urandom); tMaxZ = TW'($urandom);
    tDeltaX = TW'($urandom); tDeltaY = TW'($urandom); tDeltaZ = TW'($urandom);
    dimX = (CW+1)'($urandom); dimY = (CW+1)'($urandom); dimZ = (CW+1)'($urandom);
  endtask

  task automatic runRay(input int o[3], input bit n[3], input int tm[3],
                        input int td[3], input int dm[3]);
    bit stepFirst = 1'b0, isHit;
    int visits, cnt;
    for (int a = 0; a < 3; a++) begin
      mc[a] = o[a]; mneg[a] = n[a]; mt[a] = tm[a]; md[a] = td[a]; mdim[a] = dm[a];
    end
    originX = CW'(o[0]); originY = CW'(o[1]); originZ = CW'(o[2]);
    stepNeg = {n[2], n[1], n[0]};
    tMaxX = TW'(tm[0]); tMaxY = TW'(tm[1]); tMaxZ = TW'(tm[2]);
    tDeltaX = TW'(td[0]); tDeltaY = TW'(td[1]); tDeltaZ = TW'(td[2]);
    dimX = (CW+1)'(dm[0]); dimY = (CW+1)'(dm[1]); dimZ = (CW+1)'(dm[2]);
    chk(rayReady === 1'b1, "R2", "ready before accept", int'(rayReady), 1);
    rayValid = 1'b1;
    @(posedge clk); @(negedge clk);
    forever begin
      // R2/R8: junk ray and spurious resume held during the walk
      rayValid = 1'b1; resume = 1'b1; junkInputs();
      modelWalk(stepFirst, isHit, visits);
      cnt = 0;
      while (!(hitValid || rayMiss) && cnt < 200) begin
        chk(rayReady === 1'b0, "R2", "ready while busy", int'(rayReady), 0);
        @(posedge clk); @(negedge clk);
        cnt++;
      end
      rayValid = 1'b0; resume = 1'b0;
      chk(cnt == 2 * visits, "R9", "cycles to result", cnt, 2 * visits);
      if (isHit) begin
        chk(hitValid === 1'b1, "R5", "hit raised", int'(hitValid), 1);
        for (int s = $urandom_range(0, 3); s >= 0; s--) begin
          chk(hitValid === 1'b1 && int'(hitX) == mc[0] && int'(hitY) == mc[1]
              && int'(hitZ) == mc[2], "R4", "hit cell x*256+y*16+z",
              int'(hitX) * 256 + int'(hitY) * 16 + int'(hitZ),
              mc[0] * 256 + mc[1] * 16 + mc[2]);
          chk(int'(hitAddr) == mAddr(), "R3", "hit address", int'(hitAddr), mAddr());
          chk(int'(hitPtr) == mAddr() + 1, "R6", "held pointer", int'(hitPtr), mAddr() + 1);
          if (s > 0) begin @(posedge clk); @(negedge clk); end
        end
        hitReady = 1'b1;
        @(posedge clk); @(negedge clk);
        hitReady = 1'b0;
        for (int p = $urandom_range(1, 3); p > 0; p--) begin
          rayValid = 1'b1;
          chk(!hitValid && !rayMiss && !rayReady, "R8", "parked outputs quiet",
              int'({hitValid, rayMiss, rayReady}), 0);
          @(posedge clk); @(negedge clk);
        end
        rayValid = 1'b0;
        resume = 1'b1;
        @(posedge clk); @(negedge clk);
        resume = 1'b0;
        stepFirst = 1'b1;
      end else begin
        chk(rayMiss === 1'b1 && hitValid === 1'b0, "R7", "miss pulse", int'(rayMiss), 1);
        @(posedge clk); @(negedge clk);
        chk(rayMiss === 1'b0 && rayReady === 1'b1, "R7", "ready after miss",
            int'({rayMiss, rayReady}), 1);
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int o[3], tm[3], td[3], dm[3];
    bit n[3];
    void'($urandom(32'd2718));
    #1;
    @(negedge clk);
    chk(rayReady === 1'b1 && hitValid === 1'b0 && rayMiss === 1'b0 && gridRd === 1'b0,
        "R1", "reset outputs", int'({rayReady, hitValid, rayMiss, gridRd}), 8);
    rstN = 1'b1;
    @(negedge clk);
    chk(rayReady === 1'b1, "R1", "idle after reset", int'(rayReady), 1);

    // R4: tie on all axes must advance x first
    memMode = 2; target = 2 + 4 * (1 + 4 * 1);
    o = '{1, 1, 1}; n = '{0, 0, 0}; tm = '{5, 5, 5}; td = '{7, 7, 7}; dm = '{4, 4, 4};
    runRay(o, n, tm, td, dm);
    // R10: origin cell occupied, found without a step
    memMode = 2; target = 3 + 5 * (2 + 3 * 1);
    o = '{3, 2, 1}; n = '{1, 0, 1}; tm = '{9, 4, 6}; td = '{3, 3, 3}; dm = '{5, 3, 2};
    runRay(o, n, tm, td, dm);
    // R7: decrement from index 0 on the chosen axis, empty grid
    memMode = 1;
    o = '{0, 2, 2}; n = '{1, 0, 0}; tm = '{1, 50, 50}; td = '{4, 4, 4}; dm = '{4, 4, 4};
    runRay(o, n, tm, td, dm);
    // R7: single-cell grid
    o = '{0, 0, 0}; n = '{0, 0, 0}; tm = '{3, 2, 1}; td = '{1, 1, 1}; dm = '{1, 1, 1};
    runRay(o, n, tm, td, dm);
    // R4: z smallest, y-tie order, full walk through an empty grid
    o = '{0, 0, 0}; n = '{0, 0, 0}; tm = '{8, 6, 6}; td = '{8, 6, 6}; dm = '{3, 3, 3};
    runRay(o, n, tm, td, dm);

    // random rays over hashed occupancy
    memMode = 0;
    for (int r = 0; r < 60; r++) begin
      salt = int'($urandom_range(0, 4));
      for (int a = 0; a < 3; a++) begin
        dm[a] = int'($urandom_range(1, 6));
        o[a]  = int'($urandom_range(0, dm[a] - 1));
        n[a]  = 1'($urandom);
        tm[a] = int'($urandom_range(0, 255));
        td[a] = int'($urandom_range(1, 255));
      end
      runRay(o, n, tm, td, dm);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule